// File: doc/BRIEF.md
# Segment Selector Descriptor Loader

This unit turns a 16-bit segment selector into a cached segment descriptor. It holds a global table register (linear base and byte limit) and a local table register (a selector plus the base, limit and granularity taken from that table's descriptor). When a load is requested, it picks the table and checks that the 8-byte entry lies inside the table. It then fetches the entry as two 32-bit words over a one-cycle-latency read port and rebuilds the scattered base and limit fields. Finally it either commits the result to its cache or reports a fault with a vector number and the offending selector.

A second request type loads the local table register itself. In that case the selector always indexes the global table, and the entry found there must describe a local table. For ordinary segment loads the unit writes back the entry's accessed flag with a read-modify-write when that flag was clear. The completion pulse is held back until that write is done. Loading a null selector into the local table register empties it, and any later local-table reference is then refused.

Top module: `seg_desc_loader`

## Requirements
- R1: After reset the unit is idle: `busy`, `done` and `fault` are low, and all cached segment and local-table outputs are zero.
- R2: The descriptor byte address is the table base plus selector bits [15:3] times 8. Word 0 is read at that address and word 1 at address+4 on the next cycle. `gtab_wr_en` loads the global base and limit.
- R3: Selector bit 2 picks the global table when 0 and the local table when 1 for segment loads.
- R4: The committed base is {word1[31:24], word1[7:0], word0[31:16]}. The limit is {word1[19:16], word0[15:0]}, the access byte is word1[15:8] (bit 15 present, bit 12 code/data, bits 11:8 type, bit 8 accessed), and the flags nibble is word1[23:20] with bit 23 granularity.
- R5: If index*8+7 exceeds the selected table's limit, the unit pulses `fault` one cycle after the request with vector 13 and the selector as code. It does not read memory and leaves the cache unchanged. The local limit is scaled by 4096 (low 12 bits ones) when its granularity bit is set.
- R6: A fetched entry with the present bit clear gives vector 11, leaves the cache unchanged and writes nothing. This is reported four cycles after the request.
- R7: On a segment load whose accessed bit is clear, the unit writes word1 with bit 8 set back to address+4. `done` follows the write, five cycles after the request, and the cached access byte shows bit 0 set.
- R8: On a segment load whose accessed bit is already set, no write is made and `done` comes four cycles after the request.
- R9: A local-table load reads the global table only. It fails with vector 13 if its selector has bit 2 set (one cycle) or if the entry is not a local-table descriptor, code/data bit 0 and type 2 (four cycles). On success it updates `ldt_sel`, `ldt_base`, `ldt_limit` and `ldt_gran`. A segment load of an entry whose code/data bit is 0 fails with vector 13.
- R10: A segment load with bit 2 set while the local table register is null (bits [15:2] zero) fails with vector 13 one cycle after the request.
- R11: A local-table load with selector bits [15:2] zero makes the register null (base and limit zero) and pulses `done` one cycle later without touching memory.
- R12: `done` and `fault` are single-cycle pulses and never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gtab_wr_en | input | 1 | Load global table base and limit |
| gtab_base_in | input | 32 | New global table linear base |
| gtab_limit_in | input | 16 | New global table limit (size minus one) |
| req_valid | input | 1 | Start a load (taken only while idle) |
| req_sel | input | 16 | Selector to load |
| req_ldt | input | 1 | 1: load the local table register, 0: load a segment |
| busy | output | 1 | A load is in progress |
| done | output | 1 | Load completed and committed |
| fault | output | 1 | Load refused |
| fault_vec | output | 8 | Fault vector (11 not present, 13 protection) |
| fault_code | output | 16 | Selector that faulted |
| mem_rd_en | output | 1 | Memory read strobe, data returned next cycle |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_addr | output | 32 | Memory byte address (word aligned) |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data |
| seg_sel | output | 16 | Cached selector |
| seg_base | output | 32 | Cached segment base |
| seg_limit | output | 20 | Cached raw segment limit |
| seg_access | output | 8 | Cached access byte |
| seg_flags | output | 4 | Cached flags nibble |
| ldt_sel | output | 16 | Local table register selector |
| ldt_base | output | 32 | Local table base |
| ldt_limit | output | 20 | Local table raw limit |
| ldt_gran | output | 1 | Local table limit granularity |

## Verification
A wrong table choice or address shows up as the wrong base or limit in the cache at the `done` pulse, or as a bounds fault where a completion was due. It is visible four or five cycles after the request. A broken bounds or null check moves the `fault` pulse away from the first cycle after the request, or makes it appear where none was due. A stale accessed flag shows as a missing or extra write-back and a one-cycle shift of `done`. Because every load's completion cycle is predicted from the table contents, a timing error is caught on the cycle it happens.

// File: rtl/sdl_pkg.sv
package sdl_pkg;
  localparam int SEL_W   = 16;
  localparam int WORD_W  = 32;
  localparam int IDX_W   = SEL_W - 3;
  localparam int LIM_W   = 20;
  localparam int GRAN_SH = 12;

  localparam logic [7:0] VEC_PROT = 8'd13;
  localparam logic [7:0] VEC_NP   = 8'd11;

  localparam logic [3:0] TYPE_LOCAL_TBL = 4'd2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHK,
    ST_RD0,
    ST_RD1,
    ST_RD2,
    ST_WB
  } sdl_state_e;

  typedef struct packed {
    logic [WORD_W-1:0] base;
    logic [LIM_W-1:0]  limit;
    logic [7:0]        access;
    logic [3:0]        flags;
  } seg_desc_t;
endpackage

// File: rtl/sdl_tbl_sel.sv
module sdl_tbl_sel import sdl_pkg::*; #(
  parameter int GLIM_W = 16
) (
  input  logic [IDX_W-1:0]  idx,
  input  logic              ti,
  input  logic              ldt_mode,
  input  logic [WORD_W-1:0] gdt_base,
  input  logic [GLIM_W-1:0] gdt_lim,
  input  logic              ldt_null,
  input  logic [WORD_W-1:0] ldt_base,
  input  logic [LIM_W-1:0]  ldt_lim,
  input  logic              ldt_g,
  output logic [WORD_W-1:0] desc_addr,
  output logic              bound_err,
  output logic              null_ldt_err,
  output logic              ti_err,
  output logic              null_sel
);
  logic              use_ldt;
  logic [WORD_W-1:0] tbl_base;
  logic [WORD_W-1:0] tbl_lim;
  logic [WORD_W-1:0] ldt_lim_eff;
  logic [WORD_W-1:0] last_byte;

  always_comb begin
    use_ldt     = ti & ~ldt_mode;
    ldt_lim_eff = ldt_g ? WORD_W'({ldt_lim, {GRAN_SH{1'b1}}}) : WORD_W'(ldt_lim);
    tbl_base    = use_ldt ? ldt_base : gdt_base;
    tbl_lim     = use_ldt ? ldt_lim_eff : WORD_W'(gdt_lim);
    last_byte   = WORD_W'({idx, 3'b111});
    desc_addr   = tbl_base + WORD_W'({idx, 3'b000});
    bound_err   = last_byte > tbl_lim;
    null_ldt_err = use_ldt & ldt_null;
    ti_err      = ldt_mode & ti;
    null_sel    = ldt_mode & ~ti & (idx == '0);
  end
endmodule

// File: rtl/sdl_unpack.sv
module sdl_unpack import sdl_pkg::*; (
  input  logic [WORD_W-1:0] w0,
  input  logic [WORD_W-1:0] w1,
  output seg_desc_t         desc
);
  always_comb begin
    desc.base   = {w1[31:24], w1[7:0], w0[31:16]};
    desc.limit  = {w1[19:16], w0[15:0]};
    desc.access = w1[15:8];
    desc.flags  = w1[23:20];
  end
endmodule

// File: rtl/seg_desc_loader.sv
module seg_desc_loader import sdl_pkg::*; #(
  parameter int GLIM_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gtab_wr_en,
  input  logic [31:0]       gtab_base_in,
  input  logic [GLIM_W-1:0] gtab_limit_in,
  input  logic              req_valid,
  input  logic [15:0]       req_sel,
  input  logic              req_ldt,
  output logic              busy,
  output logic              done,
  output logic              fault,
  output logic [7:0]        fault_vec,
  output logic [15:0]       fault_code,
  output logic              mem_rd_en,
  output logic              mem_wr_en,
  output logic [31:0]       mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  output logic [15:0]       seg_sel,
  output logic [31:0]       seg_base,
  output logic [19:0]       seg_limit,
  output logic [7:0]        seg_access,
  output logic [3:0]        seg_flags,
  output logic [15:0]       ldt_sel,
  output logic [31:0]       ldt_base,
  output logic [19:0]       ldt_limit,
  output logic              ldt_gran
);
  localparam logic [WORD_W-1:0] WORD_STEP = WORD_W'(4);
  localparam logic [WORD_W-1:0] ACC_MASK  = WORD_W'(32'h0000_0100);

  sdl_state_e        state_q, state_d;
  logic [SEL_W-1:0]  sel_q;
  logic              mode_q;
  logic [WORD_W-1:0] addr_q, w0_q, w1_q;
  logic [WORD_W-1:0] gbase_q;
  logic [GLIM_W-1:0] glim_q;
  logic [SEL_W-1:0]  lsel_q;
  logic [WORD_W-1:0] lbase_q;
  logic [LIM_W-1:0]  llim_q;
  logic              lg_q;
  logic [SEL_W-1:0]  ssel_q;
  seg_desc_t         seg_q;
  logic              done_q, done_d, fault_q, fault_d;
  logic [7:0]        fvec_q, fvec_d;
  logic [SEL_W-1:0]  fcode_q, fcode_d;

  logic cap_req, cap_addr, cap_w0, cap_w1, commit_seg, commit_ldt, clear_ldt;

  logic [WORD_W-1:0] desc_addr;
  logic              bound_err, null_ldt_err, ti_err, null_sel, ldt_null;
  logic [WORD_W-1:0] w1_cur;
  seg_desc_t         ud;

  assign ldt_null = (lsel_q[SEL_W-1:2] == '0);

  sdl_tbl_sel #(.GLIM_W(GLIM_W)) u_tbl (
    .idx          (sel_q[SEL_W-1:3]),
    .ti           (sel_q[2]),
    .ldt_mode     (mode_q),
    .gdt_base     (gbase_q),
    .gdt_lim      (glim_q),
    .ldt_null     (ldt_null),
    .ldt_base     (lbase_q),
    .ldt_lim      (llim_q),
    .ldt_g        (lg_q),
    .desc_addr    (desc_addr),
    .bound_err    (bound_err),
    .null_ldt_err (null_ldt_err),
    .ti_err       (ti_err),
    .null_sel     (null_sel)
  );

  assign w1_cur = (state_q == ST_RD2) ? mem_rdata : (w1_q | ACC_MASK);

  sdl_unpack u_unpack (
    .w0   (w0_q),
    .w1   (w1_cur),
    .desc (ud)
  );

  always_comb begin
    state_d    = state_q;
    done_d     = 1'b0;
    fault_d    = 1'b0;
    fvec_d     = fvec_q;
    fcode_d    = fcode_q;
    cap_req    = 1'b0;
    cap_addr   = 1'b0;
    cap_w0     = 1'b0;
    cap_w1     = 1'b0;
    commit_seg = 1'b0;
    commit_ldt = 1'b0;
    clear_ldt  = 1'b0;
    case (state_q)
      ST_IDLE: if (req_valid) begin
        cap_req = 1'b1;
        state_d = ST_CHK;
      end
      ST_CHK: begin
        state_d = ST_IDLE;
        if (null_sel) begin
          clear_ldt = 1'b1;
          done_d    = 1'b1;
        end else if (ti_err || null_ldt_err || bound_err) begin
          fault_d = 1'b1;
          fvec_d  = VEC_PROT;
          fcode_d = sel_q;
        end else begin
          cap_addr = 1'b1;
          state_d  = ST_RD0;
        end
      end
      ST_RD0: state_d = ST_RD1;
      ST_RD1: begin
        cap_w0  = 1'b1;
        state_d = ST_RD2;
      end
      ST_RD2: begin
        cap_w1  = 1'b1;
        state_d = ST_IDLE;
        if (!ud.access[7]) begin
          fault_d = 1'b1;
          fvec_d  = VEC_NP;
          fcode_d = sel_q;
        end else if (mode_q) begin
          if (!ud.access[4] && ud.access[3:0] == TYPE_LOCAL_TBL) begin
            commit_ldt = 1'b1;
            done_d     = 1'b1;
          end else begin
            fault_d = 1'b1;
            fvec_d  = VEC_PROT;
            fcode_d = sel_q;
          end
        end else if (!ud.access[4]) begin
          fault_d = 1'b1;
          fvec_d  = VEC_PROT;
          fcode_d = sel_q;
        end else if (ud.access[0]) begin
          commit_seg = 1'b1;
          done_d     = 1'b1;
        end else begin
          state_d = ST_WB;
        end
      end
      ST_WB: begin
        commit_seg = 1'b1;
        done_d     = 1'b1;
        state_d    = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sel_q   <= '0;
      mode_q  <= 1'b0;
      addr_q  <= '0;
      w0_q    <= '0;
      w1_q    <= '0;
      gbase_q <= '0;
      glim_q  <= '0;
      lsel_q  <= '0;
      lbase_q <= '0;
      llim_q  <= '0;
      lg_q    <= 1'b0;
      ssel_q  <= '0;
      seg_q   <= '0;
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      fvec_q  <= '0;
      fcode_q <= '0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      fault_q <= fault_d;
      fvec_q  <= fvec_d;
      fcode_q <= fcode_d;
      if (gtab_wr_en) begin
        gbase_q <= gtab_base_in;
        glim_q  <= gtab_limit_in;
      end
      if (cap_req) begin
        sel_q  <= req_sel;
        mode_q <= req_ldt;
      end
      if (cap_addr) addr_q <= desc_addr;
      if (cap_w0)   w0_q   <= mem_rdata;
      if (cap_w1)   w1_q   <= mem_rdata;
      if (commit_ldt) begin
        lsel_q  <= sel_q;
        lbase_q <= ud.base;
        llim_q  <= ud.limit;
        lg_q    <= ud.flags[3];
      end else if (clear_ldt) begin
        lsel_q  <= sel_q;
        lbase_q <= '0;
        llim_q  <= '0;
        lg_q    <= 1'b0;
      end
      if (commit_seg) begin
        ssel_q <= sel_q;
        seg_q  <= ud;
      end
    end
  end

  always_comb begin
    mem_rd_en = (state_q == ST_RD0) || (state_q == ST_RD1);
    mem_wr_en = (state_q == ST_WB);
    mem_addr  = (state_q == ST_RD0) ? addr_q : addr_q + WORD_STEP;
    mem_wdata = w1_q | ACC_MASK;
  end

  assign busy       = (state_q != ST_IDLE);
  assign done       = done_q;
  assign fault      = fault_q;
  assign fault_vec  = fvec_q;
  assign fault_code = fcode_q;
  assign seg_sel    = ssel_q;
  assign seg_base   = seg_q.base;
  assign seg_limit  = seg_q.limit;
  assign seg_access = seg_q.access;
  assign seg_flags  = seg_q.flags;
  assign ldt_sel    = lsel_q;
  assign ldt_base   = lbase_q;
  assign ldt_limit  = llim_q;
  assign ldt_gran   = lg_q;
endmodule

// File: rtl/seg_desc_loader_chk.sv
module seg_desc_loader_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        done,
  input logic        fault,
  input logic        mem_rd_en,
  input logic        mem_wr_en,
  input logic [31:0] mem_addr,
  input logic [31:0] mem_wdata,
  input logic [31:0] seg_base,
  input logic [15:0] seg_sel
);
  // R12: completion and refusal are exclusive
  a_r12_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fault));

  // R12: completion is a single-cycle pulse
  a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R2: second word follows the first at the next word address
  a_r2_word_pair: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_rd_en) |=> (mem_rd_en && mem_addr == $past(mem_addr) + 32'd4));

  // R7: a write-back sets the accessed bit and is followed by completion
  a_r7_wb_sets_acc: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> mem_wdata[8]);

  a_r7_wb_then_done: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |=> done);

  // R5/R6: a refused load leaves the segment cache unchanged
  a_r5_fault_keeps_cache: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> ($stable(seg_base) && $stable(seg_sel)));
endmodule

bind seg_desc_loader seg_desc_loader_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .done      (done),
  .fault     (fault),
  .mem_rd_en (mem_rd_en),
  .mem_wr_en (mem_wr_en),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .seg_base  (seg_base),
  .seg_sel   (seg_sel)
);

// File: tb/seg_desc_loader_tb_top.sv
module seg_desc_loader_tb_top;
  logic clk = 1'b0;
  logic rst_n;
  always #10 clk = ~clk;

  logic        gtab_wr_en;
  logic [31:0] gtab_base_in;
  logic [15:0] gtab_limit_in;
  logic        req_valid;
  logic [15:0] req_sel;
  logic        req_ldt;
  logic        busy, done, fault;
  logic [7:0]  fault_vec;
  logic [15:0] fault_code;
  logic        mem_rd_en, mem_wr_en;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [15:0] seg_sel;
  logic [31:0] seg_base;
  logic [19:0] seg_limit;
  logic [7:0]  seg_access;
  logic [3:0]  seg_flags;
  logic [15:0] ldt_sel;
  logic [31:0] ldt_base;
  logic [19:0] ldt_limit;
  logic        ldt_gran;

  seg_desc_loader dut_i (.*);

  // memory model: one-cycle read latency, bench poke port
  logic [31:0] mem [0:255];
  logic        tb_we;
  logic [7:0]  tb_wa;
  logic [31:0] tb_wd;
  always @(posedge clk) begin
    if (tb_we) mem[tb_wa] <= tb_wd;
    else if (mem_wr_en) mem[mem_addr[9:2]] <= mem_wdata;
    if (mem_rd_en) mem_rdata <= mem[mem_addr[9:2]];
  end

  int n_tests = 0;
  int n_fail  = 0;

  // reference model state
  logic [31:0] m_gbase = '0;
  logic [15:0] m_glim = '0;
  logic [15:0] m_lsel = '0;
  logic [31:0] m_lbase = '0;
  logic [19:0] m_llim = '0;
  logic        m_lg = 1'b0;
  logic [15:0] e_sel = '0;
  logic [31:0] e_base = '0;
  logic [19:0] e_lim = '0;
  logic [7:0]  e_acc = '0;
  logic [3:0]  e_flags = '0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic poke(input logic [31:0] byte_addr, input logic [31:0] d);
    tb_we = 1'b1; tb_wa = byte_addr[9:2]; tb_wd = d;
    @(negedge clk);
    tb_we = 1'b0;
  endtask

  task automatic put_desc(input logic [31:0] a, input logic [31:0] base,
                          input logic [19:0] lim, input logic [7:0] acc,
                          input logic [3:0] flg);
    poke(a, {base[15:0], lim[15:0]});
    poke(a + 4, {base[31:24], flg, lim[19:16], acc, base[23:16]});
  endtask

  task automatic model(input logic [15:0] s, input bit ldt,
                       output int k, output bit f, output int vec);
    int idx;
    bit ti;
    longint unsigned tb, tl, off;
    logic [31:0] w0, w1;
    int wa;
    idx = int'(s[15:3]);
    ti  = s[2];
    f = 1'b0; vec = 0; k = 1;
    if (ldt && !ti && idx == 0) begin
      m_lsel = s; m_lbase = '0; m_llim = '0; m_lg = 1'b0;
      return;
    end
    f = 1'b1; vec = 13;
    if (ldt && ti) return;
    if (!ldt && ti) begin
      if (m_lsel[15:2] == 0) return;
      tb = m_lbase;
      tl = m_lg ? (longint'(m_llim) * 4096 + 4095) : longint'(m_llim);
    end else begin
      tb = m_gbase;
      tl = m_glim;
    end
    off = idx * 8 + 7;
    if (off > tl) return;
    wa = int'((tb + idx * 8) >> 2);
    w0 = mem[wa];
    w1 = mem[wa + 1];
    k = 4;
    if (!w1[15]) begin vec = 11; return; end
    if (ldt) begin
      if (w1[12] || w1[11:8] != 4'd2) return;
      f = 1'b0; vec = 0;
      m_lsel = s;
      m_lbase = {w1[31:24], w1[7:0], w0[31:16]};
      m_llim = {w1[19:16], w0[15:0]};
      m_lg = w1[23];
      return;
    end
    if (!w1[12]) return;
    f = 1'b0; vec = 0;
    if (!w1[8]) k = 5;
    e_sel = s;
    e_base = {w1[31:24], w1[7:0], w0[31:16]};
    e_lim = {w1[19:16], w0[15:0]};
    e_acc = w1[15:8] | 8'h01;
    e_flags = w1[23:20];
  endtask

  task automatic run(input logic [15:0] s, input bit ldt, input string rq);
    int k, vec, obs_k;
    bit f, obs_f, timing_ok;
    logic [31:0] wb_before;
    int wb_idx;
    model(s, ldt, k, f, vec);
    wb_idx = 0;
    wb_before = '0;
    if (!ldt && !f) begin
      wb_idx = int'((s[2] ? m_lbase : m_gbase) + s[15:3] * 8 + 4) >> 2;
      wb_before = mem[wb_idx];
    end
    req_valid = 1'b1; req_sel = s; req_ldt = ldt;
    @(negedge clk);
    req_valid = 1'b0;
    timing_ok = 1'b1; obs_k = 0; obs_f = 1'b0;
    for (int c = 1; c <= 6; c++) begin
      @(negedge clk);
      if ((done || fault) && obs_k == 0) begin obs_k = c; obs_f = fault; end
      if (done  != (c == k && !f)) timing_ok = 1'b0;
      if (fault != (c == k && f))  timing_ok = 1'b0;
    end
    chk(timing_ok, rq, "completion cycle/kind", {obs_f, 8'(obs_k)}, {f, 8'(k)});
    chk(!busy, rq, "idle after load", busy, 0);
    if (f) begin
      chk(fault_vec == 8'(vec), rq, "fault vector", fault_vec, vec);
      chk(fault_code == s, rq, "fault code", fault_code, s);
    end
    chk({seg_sel, seg_base, seg_access, seg_flags} == {e_sel, e_base, e_acc, e_flags},
        rq, "segment cache sel/base/acc/flags",
        {seg_sel, seg_base, seg_access, seg_flags}, {e_sel, e_base, e_acc, e_flags});
    chk(seg_limit == e_lim, rq, "segment limit", seg_limit, e_lim);
    chk({ldt_sel, ldt_base, ldt_gran} == {m_lsel, m_lbase, m_lg} && ldt_limit == m_llim,
        rq, "local table register", {ldt_sel, ldt_base, ldt_limit},
        {m_lsel, m_lbase, m_llim});
    if (!ldt && !f) begin
      if (k == 5)
        chk(mem[wb_idx] == (wb_before | 32'h100), "R7", "accessed write-back",
            mem[wb_idx], wb_before | 32'h100);
      else
        chk(mem[wb_idx] == wb_before, "R8", "no write-back", mem[wb_idx], wb_before);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    gtab_wr_en = 1'b0; gtab_base_in = '0; gtab_limit_in = '0;
    req_valid = 1'b0; req_sel = '0; req_ldt = 1'b0;
    tb_we = 1'b0; tb_wa = '0; tb_wd = '0;
    @(negedge clk);
    for (int i = 0; i < 256; i++) poke(32'(i * 4), 32'h0);
    // global table at 0x100
    put_desc(32'h108, 32'h12345678, 20'hABCDE, 8'h9A, 4'hC);
    put_desc(32'h110, 32'hCAFE0000, 20'h00FFF, 8'hF3, 4'h1);
    put_desc(32'h118, 32'h00001000, 20'h00010, 8'h12, 4'h0);
    put_desc(32'h120, 32'h00000200, 20'h00017, 8'h82, 4'h0);
    put_desc(32'h128, 32'h00000300, 20'h00067, 8'h89, 4'h0);
    put_desc(32'h138, 32'h0BADF00D, 20'h00001, 8'h93, 4'h4);
    // local table at 0x200
    put_desc(32'h208, 32'h00400010, 20'h12345, 8'hD2, 4'h8);
    put_desc(32'h210, 32'h77665544, 20'hFFFFF, 8'hFB, 4'hC);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(!busy && !done && !fault, "R1", "idle flags", {busy, done, fault}, 0);
    chk(seg_base == 0 && seg_sel == 0 && seg_limit == 0 && seg_access == 0,
        "R1", "segment cache cleared", seg_base, 0);
    chk(ldt_sel == 0 && ldt_base == 0 && ldt_limit == 0, "R1", "local table cleared",
        ldt_base, 0);
    // R2: program the global table register
    gtab_wr_en = 1'b1; gtab_base_in = 32'h100; gtab_limit_in = 16'h003F;
    @(negedge clk);
    gtab_wr_en = 1'b0;
    m_gbase = 32'h100; m_glim = 16'h003F;

    run(16'h0008, 1'b0, "R2 R4 R7");   // global idx1, accessed clear
    run(16'h0013, 1'b0, "R4 R8");      // global idx2, already accessed
    run(16'h0018, 1'b0, "R6");         // not present
    run(16'h0040, 1'b0, "R5");         // index 8 past limit 0x3F
    run(16'h0038, 1'b0, "R5");         // index 7 ends exactly at limit
    run(16'h000C, 1'b0, "R10");        // local table still null
    run(16'h0020, 1'b1, "R9");         // load local table register
    run(16'h0024, 1'b1, "R9");         // local table selector with bit 2 set
    run(16'h0028, 1'b1, "R9");         // wrong descriptor class
    run(16'h000C, 1'b0, "R3 R7");      // local idx1
    run(16'h0016, 1'b0, "R3 R8");      // local idx2
    run(16'h001C, 1'b0, "R5");         // local idx3 past limit 0x17
    run(16'h0028, 1'b0, "R9");         // segment load of system entry
    run(16'h0008, 1'b0, "R8");         // idx1 now accessed
    run(16'h0001, 1'b1, "R11");        // null local table selector
    run(16'h0014, 1'b0, "R10");        // local reference after null load
    chk(!done && !fault, "R12", "no stray pulses", {done, fault}, 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule